// File: doc/BRIEF.md
# CAN Receive Acceptance Filter and Frame Queue

This block sits behind a CAN frame decoder. Each decoded frame arrives in one cycle as a 31-bit key, a length code and eight data bytes. The key carries the 29-bit identifier with two flag bits above it. The block compares the key against a table of sixteen identifier/mask filters. A frame that some filter accepts is written into an eight-entry ring, together with the index of the filter that accepted it. A consumer reads the ring from its head and pops entries. Frames that no filter accepts are dropped without a trace.

A control side edits the table with add and remove commands. Each command gets a registered response one cycle later, carrying a slot index or an error. A slot whose identifier is zero counts as free, and a table with no used slot lets every frame through. A frame that is accepted while the ring is full is discarded, and a one-cycle drop pulse is raised. A frame and a command presented in the same cycle are judged against the table as it stood before that command.

Top module: `can_accept_queue`

## Requirements
- R1: After reset the ring is empty (`out_valid`=0, `out_count`=0), no filter slot is used, and `rsp_valid` and `rx_drop` are 0.
- R2: An add command with a key not yet in the table writes the key and mask into the lowest-index free slot. In the next cycle it answers with `rsp_valid`=1, `rsp_err`=0 and that slot on `rsp_slot`.
- R3: An add command whose key is already held in a slot answers with that slot and no error. The stored mask is left unchanged and no second slot is taken.
- R4: An add command for a new key while all sixteen slots are used answers with `rsp_err`=1 and leaves the table unchanged.
- R5: A remove command frees the slot that holds its key and answers with that slot. Later adds may reuse the slot. Removing a key that is not present answers with `rsp_err`=1.
- R6: An add or remove command with key 0 answers with `rsp_err`=1 and has no effect, because key 0 marks a free slot.
- R7: A frame matches a used slot when (slot mask AND slot key) equals (slot mask AND frame key). Key bits outside the mask are ignored. When at least one slot is used, a frame that matches none is not stored.
- R8: While no slot is used, every frame is stored, with `out_slot`=0.
- R9: A stored frame carries on `out_slot` the lowest index among the used slots it matches.
- R10: The ring holds up to 8 frames in arrival order. Its head is shown on `out_key`, `out_dlc`, `out_data` and `out_slot` while `out_valid`=1. `pop` removes the head. A `pop` on an empty ring has no effect.
- R11: An accepted frame that arrives while the ring holds 8 frames and `pop` is low is discarded. The ring contents stay the same, and `rx_drop` is high for exactly the next cycle.
- R12: On a full ring, an accepted frame that arrives in the same cycle as `pop` is stored. The count stays at 8 and `rx_drop` stays low.
- R13: Key layout: bit 30 is the extended-format flag, bit 29 is the remote-request flag, and bits 28:0 are the identifier. The flag bits take part in matching like any other key bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frm_valid | input | 1 | A decoded frame is present this cycle |
| frm_key | input | 31 | Frame key: flags and identifier (R13) |
| frm_dlc | input | 4 | Frame length code |
| frm_data | input | 64 | Frame payload bytes |
| cmd_valid | input | 1 | A table command is present this cycle |
| cmd_remove | input | 1 | 1 = remove, 0 = add |
| cmd_key | input | 31 | Filter key for the command |
| cmd_mask | input | 31 | Filter mask, used by add only |
| rsp_valid | output | 1 | Response to the previous cycle's command |
| rsp_err | output | 1 | The command failed |
| rsp_slot | output | 4 | Slot index used by the command |
| pop | input | 1 | Consume the ring head |
| out_valid | output | 1 | The ring holds at least one frame |
| out_key | output | 31 | Head frame key |
| out_dlc | output | 4 | Head frame length code |
| out_data | output | 64 | Head frame payload |
| out_slot | output | 4 | Filter slot that accepted the head frame |
| out_count | output | 4 | Number of frames in the ring |
| rx_drop | output | 1 | One-cycle pulse: an accepted frame was lost to a full ring |

## Verification
A corrupted slot key or a mis-set free flag cannot be seen directly. It appears at the ports in two ways. A later add of the same key answers with a different slot, or a frame that should have been kept never raises `out_count` on the cycle after it arrives. A wrong ring pointer or count appears within one pop: the head shows a key out of arrival order, or `out_valid` disagrees with the number of frames pushed. The bench therefore reaches every internal state through commands and frames, reads it back through responses and ring order, and looks most closely at the cycles where the table or the ring is full.

// File: rtl/can_acc_pkg.sv
// Shared widths and helpers for the CAN acceptance queue.
// Assumes: key layout {ext flag, rtr flag, 29-bit identifier}.
package can_acc_pkg;
    localparam int KEY_W  = 31;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;

    typedef logic [KEY_W-1:0] key_t;

    // True when two keys agree on every bit selected by the mask.
    function automatic logic masked_equal(input key_t a, input key_t b, input key_t m);
        return (a & m) == (b & m);
    endfunction
endpackage

// File: rtl/cafq_filter_table.sv
// Filter table: holds N_FILT key/mask pairs, serves add/remove commands with a
// registered response, and classifies a probe key combinationally.
// Assumes: key value 0 marks a free slot; commands with key 0 are rejected.
module cafq_filter_table
    import can_acc_pkg::*;
#(
    parameter int N_FILT = 16,
    localparam int SLOT_W = $clog2(N_FILT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_remove,
    input  key_t              cmd_key,
    input  key_t              cmd_mask,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [SLOT_W-1:0] rsp_slot,
    input  key_t              probe_key,
    output logic              probe_hit,
    output logic [SLOT_W-1:0] probe_slot
);
    key_t fid_q   [N_FILT];
    key_t fmask_q [N_FILT];

    logic [N_FILT-1:0] used, same, match;

    // Per-slot status: in use, holds the command key, accepts the probe.
    for (genvar g = 0; g < N_FILT; g++) begin : g_slot
        assign used[g]  = fid_q[g] != '0;
        assign same[g]  = used[g] && (fid_q[g] == cmd_key);
        assign match[g] = used[g] && masked_equal(fid_q[g], probe_key, fmask_q[g]);
    end

    logic              same_any, free_any, match_any;
    logic [SLOT_W-1:0] same_idx, free_idx, match_idx;

    // Lowest-index encoders for duplicate, free and matching slots.
    always_comb begin
        same_any = 1'b0; free_any = 1'b0; match_any = 1'b0;
        same_idx = '0;   free_idx = '0;   match_idx = '0;
        for (int i = N_FILT - 1; i >= 0; i--) begin
            if (same[i])  begin same_any  = 1'b1; same_idx  = SLOT_W'(i); end
            if (!used[i]) begin free_any  = 1'b1; free_idx  = SLOT_W'(i); end
            if (match[i]) begin match_any = 1'b1; match_idx = SLOT_W'(i); end
        end
    end

    // Acceptance: empty table passes all, otherwise the first match decides.
    assign probe_hit  = !(|used) || match_any;
    assign probe_slot = match_any ? match_idx : '0;

    // Table update and command response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_FILT; i++) begin
                fid_q[i]   <= '0;
                fmask_q[i] <= '0;
            end
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_slot  <= '0;
        end else begin
            rsp_valid <= cmd_valid;
            if (cmd_valid) begin
                rsp_err  <= 1'b1;
                rsp_slot <= '0;
                if (cmd_key != '0) begin
                    if (cmd_remove) begin
                        if (same_any) begin
                            fid_q[same_idx] <= '0;
                            rsp_err         <= 1'b0;
                            rsp_slot        <= same_idx;
                        end
                    end else if (same_any) begin
                        rsp_err  <= 1'b0;
                        rsp_slot <= same_idx;
                    end else if (free_any) begin
                        fid_q[free_idx]   <= cmd_key;
                        fmask_q[free_idx] <= cmd_mask;
                        rsp_err           <= 1'b0;
                        rsp_slot          <= free_idx;
                    end
                end
            end
        end
    end

    // A successful add leaves the key stored in the reported slot.
    assert_add_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_remove && cmd_key != '0) |=>
            (rsp_valid && (rsp_err || fid_q[rsp_slot] == $past(cmd_key))));

    // A successful remove leaves the reported slot free.
    assert_remove_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_remove) |=> (rsp_err || fid_q[rsp_slot] == '0));

    // A new key offered to a full table is refused.
    assert_full_refuses_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_remove && cmd_key != '0 && (&used) && !(|same)) |=> rsp_err);

    // Key 0 is never accepted as a command.
    assert_zero_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_key == '0) |=> (rsp_valid && rsp_err));
endmodule

// File: rtl/cafq_ring.sv
// Ring buffer of DEPTH words with first-word-fall-through head.
// Assumes: DEPTH is a power of two; pointers wrap by masking with DEPTH-1.
module cafq_ring #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             nonempty,
    output logic [CNT_W-1:0] count,
    output logic             drop_err
);
    localparam logic [PTR_W-1:0] WRAP = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rptr, wptr;
    logic             full, do_pop, do_push;

    assign full    = count == CNT_W'(DEPTH);
    assign do_pop  = pop && (count != '0);
    assign do_push = push_req && (!full || do_pop);

    assign nonempty = count != '0;
    assign dout     = mem[rptr];

    // Storage write at the tail.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    // Pointer, occupancy and drop-pulse update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr     <= '0;
            wptr     <= '0;
            count    <= '0;
            drop_err <= 1'b0;
        end else begin
            if (do_push) wptr <= (wptr + 1'b1) & WRAP;
            if (do_pop)  rptr <= (rptr + 1'b1) & WRAP;
            count    <= count + CNT_W'(do_push) - CNT_W'(do_pop);
            drop_err <= push_req && !do_push;
        end
    end

    // Occupancy never exceeds the depth.
    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // Full ring without pop: frame lost, count held, pulse raised.
    assert_full_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !pop) |=> (drop_err && count == CNT_W'(DEPTH)));

    // Full ring with pop and push together: still full, no pulse.
    assert_full_swap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && pop) |=> (!drop_err && count == CNT_W'(DEPTH)));

    // Popping an empty ring with no push keeps it empty.
    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !push_req) |=> count == '0);
endmodule

// File: rtl/can_accept_queue.sv
// Top: filters decoded CAN frames through the slot table and queues accepted
// frames with their matching slot index.
// Assumes: a frame and a command in one cycle see the table before the command.
module can_accept_queue
    import can_acc_pkg::*;
#(
    parameter int N_FILT = 16,
    parameter int DEPTH  = 8,
    localparam int SLOT_W = $clog2(N_FILT),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int ENT_W  = KEY_W + DLC_W + DATA_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [KEY_W-1:0]  frm_key,
    input  logic [DLC_W-1:0]  frm_dlc,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              cmd_valid,
    input  logic              cmd_remove,
    input  logic [KEY_W-1:0]  cmd_key,
    input  logic [KEY_W-1:0]  cmd_mask,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [SLOT_W-1:0] rsp_slot,
    input  logic              pop,
    output logic              out_valid,
    output logic [KEY_W-1:0]  out_key,
    output logic [DLC_W-1:0]  out_dlc,
    output logic [DATA_W-1:0] out_data,
    output logic [SLOT_W-1:0] out_slot,
    output logic [CNT_W-1:0]  out_count,
    output logic              rx_drop
);
    logic              hit;
    logic [SLOT_W-1:0] hit_slot;
    logic [ENT_W-1:0]  ent_in, ent_out;

    cafq_filter_table #(.N_FILT(N_FILT)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_remove (cmd_remove),
        .cmd_key    (cmd_key),
        .cmd_mask   (cmd_mask),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .rsp_slot   (rsp_slot),
        .probe_key  (frm_key),
        .probe_hit  (hit),
        .probe_slot (hit_slot)
    );

    // Pack the accepted frame with its slot index for storage.
    assign ent_in = {frm_key, frm_dlc, frm_data, hit_slot};

    cafq_ring #(.DEPTH(DEPTH), .W(ENT_W)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (frm_valid && hit),
        .din      (ent_in),
        .pop      (pop),
        .dout     (ent_out),
        .nonempty (out_valid),
        .count    (out_count),
        .drop_err (rx_drop)
    );

    // Unpack the ring head onto the consumer ports.
    assign {out_key, out_dlc, out_data, out_slot} = ent_out;

    // The drop pulse only follows an incoming frame.
    assert_drop_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drop |-> $past(frm_valid));
endmodule

// File: tb/tb_can_accept_queue.sv
`timescale 1ns/1ps
module tb_can_accept_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0;
    logic [30:0] frm_key = '0;
    logic [3:0]  frm_dlc = '0;
    logic [63:0] frm_data = '0;
    logic        cmd_valid = 1'b0, cmd_remove = 1'b0;
    logic [30:0] cmd_key = '0, cmd_mask = '0;
    logic        rsp_valid, rsp_err;
    logic [3:0]  rsp_slot;
    logic        pop = 1'b0;
    logic        out_valid;
    logic [30:0] out_key;
    logic [3:0]  out_dlc;
    logic [63:0] out_data;
    logic [3:0]  out_slot;
    logic [3:0]  out_count;
    logic        rx_drop;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    localparam logic [30:0] ALL = 31'h7FFF_FFFF;

    always #2 clk = ~clk;

    can_accept_queue dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input bit rem, input logic [30:0] k, input logic [30:0] m,
                          output bit err, output logic [3:0] slot);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_remove = rem; cmd_key = k; cmd_mask = m;
        @(negedge clk);
        cmd_valid = 1'b0;
        err = rsp_err; slot = rsp_slot;
        chk(rsp_valid === 1'b1, "R2 rsp_valid", 64'(rsp_valid), 64'd1);
    endtask

    task automatic push(input logic [30:0] k, input logic [63:0] d, output bit drop);
        @(negedge clk);
        frm_valid = 1'b1; frm_key = k; frm_dlc = 4'd8; frm_data = d;
        @(negedge clk);
        frm_valid = 1'b0;
        drop = rx_drop;
    endtask

    task automatic pop_one(output logic [30:0] k, output logic [63:0] d, output logic [3:0] s);
        @(negedge clk);
        k = out_key; d = out_data; s = out_slot;
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic t_reset;
        chk(out_valid === 1'b0 && out_count === 4'd0, "R1 ring empty", 64'(out_count), 64'd0);
        chk(rsp_valid === 1'b0 && rx_drop === 1'b0, "R1 idle outputs", 64'({rsp_valid, rx_drop}), 64'd0);
    endtask

    task automatic t_add_match;
        bit e, dr; logic [3:0] s; logic [30:0] k; logic [63:0] d;
        do_cmd(0, 31'h100, ALL, e, s);
        chk(!e && s == 0, "R2 first add slot", 64'(s), 64'd0);
        do_cmd(0, 31'h200, 31'h7FF, e, s);
        chk(!e && s == 1, "R2 second add slot", 64'(s), 64'd1);
        do_cmd(0, 31'h100, 31'h0, e, s);
        chk(!e && s == 0, "R3 duplicate add slot", 64'(s), 64'd0);
        push(31'h300, 64'h33, dr);
        chk(out_count == 0, "R7 R3 unmatched frame dropped", 64'(out_count), 64'd0);
        push(31'h100, 64'h11, dr);
        chk(out_count == 1, "R7 matched frame stored", 64'(out_count), 64'd1);
        push(31'h200 | (31'd1 << 20), 64'h21, dr);
        chk(out_count == 2, "R7 unmasked bits ignored", 64'(out_count), 64'd2);
        do_cmd(0, 31'h101, 31'h0, e, s);
        chk(!e && s == 2, "R2 third add slot", 64'(s), 64'd2);
        push(31'h200, 64'h22, dr);
        push(31'h555, 64'h55, dr);
        push((31'd1 << 30) | 31'h100, 64'hE1, dr);
        chk(out_count == 5, "R7 count after mixed frames", 64'(out_count), 64'd5);
        pop_one(k, d, s);
        chk(k == 31'h100 && s == 0 && d == 64'h11, "R10 head 0x100 slot0", 64'(k), 64'h100);
        pop_one(k, d, s);
        chk(s == 1 && d == 64'h21, "R7 masked frame slot1", 64'(s), 64'd1);
        pop_one(k, d, s);
        chk(k == 31'h200 && s == 1, "R9 lowest matching slot", 64'(s), 64'd1);
        pop_one(k, d, s);
        chk(k == 31'h555 && s == 2, "R9 catch-all slot", 64'(s), 64'd2);
        pop_one(k, d, s);
        chk(s == 2 && d == 64'hE1, "R13 ext flag breaks exact match", 64'(s), 64'd2);
        chk(out_valid == 0, "R10 ring drained", 64'(out_valid), 64'd0);
    endtask

    task automatic t_remove;
        bit e; logic [3:0] s;
        do_cmd(1, 31'h200, '0, e, s);
        chk(!e && s == 1, "R5 remove slot", 64'(s), 64'd1);
        do_cmd(1, 31'h200, '0, e, s);
        chk(e, "R5 remove absent errors", 64'(e), 64'd1);
        do_cmd(0, 31'h400, ALL, e, s);
        chk(!e && s == 1, "R5 freed slot reused", 64'(s), 64'd1);
        do_cmd(0, 31'h0, ALL, e, s);
        chk(e, "R6 add key0 errors", 64'(e), 64'd1);
        do_cmd(1, 31'h0, '0, e, s);
        chk(e, "R6 remove key0 errors", 64'(e), 64'd1);
        do_cmd(1, 31'h100, '0, e, s);
        do_cmd(1, 31'h101, '0, e, s);
        do_cmd(1, 31'h400, '0, e, s);
        chk(!e && s == 1, "R5 cleanup remove", 64'(s), 64'd1);
    endtask

    task automatic t_full_table;
        bit e, dr; logic [3:0] s; logic [30:0] k; logic [63:0] d;
        for (int i = 1; i <= 16; i++) begin
            do_cmd(0, 31'(i), ALL, e, s);
            chk(!e && s == 4'(i - 1), "R2 fill slot", 64'(s), 64'(i - 1));
        end
        do_cmd(0, 31'h77, ALL, e, s);
        chk(e, "R4 add to full table errors", 64'(e), 64'd1);
        do_cmd(0, 31'd5, '0, e, s);
        chk(!e && s == 4, "R3 duplicate in full table", 64'(s), 64'd4);
        push(31'h77, 64'h77, dr);
        chk(out_count == 0, "R4 refused key not stored", 64'(out_count), 64'd0);
        push(31'd9, 64'h9, dr);
        pop_one(k, d, s);
        chk(k == 31'd9 && s == 8, "R9 slot of key 9", 64'(s), 64'd8);
        for (int i = 1; i <= 16; i++) do_cmd(1, 31'(i), '0, e, s);
        chk(!e && s == 15, "R5 last remove", 64'(s), 64'd15);
    endtask

    task automatic t_empty_accept;
        bit dr; logic [3:0] s; logic [30:0] k; logic [63:0] d;
        push((31'd1 << 29) | 31'h1ABCDEF, 64'hDEAD, dr);
        pop_one(k, d, s);
        chk(k == ((31'd1 << 29) | 31'h1ABCDEF) && s == 0 && d == 64'hDEAD,
            "R8 empty table accepts", 64'(k), 64'((31'd1 << 29) | 31'h1ABCDEF));
    endtask

    task automatic t_ring;
        bit dr; logic [3:0] s; logic [30:0] k; logic [63:0] d;
        for (int i = 0; i < 8; i++) push(31'(8'h10 + i), 64'(8'hA0 + i), dr);
        chk(out_count == 8, "R10 ring full count", 64'(out_count), 64'd8);
        push(31'h55, 64'h55, dr);
        chk(dr == 1 && out_count == 8, "R11 drop pulse on full", 64'(dr), 64'd1);
        chk(out_key == 31'h10, "R11 head unchanged", 64'(out_key), 64'h10);
        @(negedge clk);
        chk(rx_drop == 0, "R11 pulse one cycle", 64'(rx_drop), 64'd0);
        frm_valid = 1'b1; frm_key = 31'h99; frm_data = 64'h99; pop = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0; pop = 1'b0;
        chk(out_count == 8 && rx_drop == 0, "R12 swap keeps full", 64'(out_count), 64'd8);
        for (int i = 1; i < 8; i++) begin
            pop_one(k, d, s);
            chk(k == 31'(8'h10 + i) && d == 64'(8'hA0 + i), "R10 FIFO order", 64'(k), 64'(8'h10 + i));
        end
        pop_one(k, d, s);
        chk(k == 31'h99, "R12 swapped frame kept", 64'(k), 64'h99);
        @(negedge clk); pop = 1'b1;
        @(negedge clk); pop = 1'b0;
        chk(out_count == 0 && out_valid == 0, "R10 pop on empty", 64'(out_count), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add_match();
        t_remove();
        t_full_table();
        t_empty_accept();
        t_ring();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule